// File: doc/BRIEF.md
# Link Retransmission Sender with Loopback Diversion

This block is the sending half of one output port of a store-and-forward mesh router. It takes one complete packet at a time from the port's buffer, keeps a private copy, and sends that copy to the neighbouring router one flit per cycle. It then waits for the neighbour's verdict. The neighbour answers once per packet: a positive acknowledgement (Ack) after every flit has arrived and passed its check, or a negative acknowledgement (Nack) when the packet was damaged.

On a Nack the whole packet is sent again from the stored copy. The neighbour may reject the same packet three times in a row. The controller then stops using the link and streams the copy into the router's loopback path, so that the packet can be routed out through another port. For every packet, a one-cycle outcome pulse reports whether it was delivered or diverted, and by which input port it entered the router. Surrounding fault-history logic uses this pulse to tell lasting faults from transient ones.

Top module: `linkRetryTx`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `srcReady` is 1 and `txValid`, `loopValid` and `doneValid` are 0.
- R2: A flit is taken when `srcValid` and `srcReady` are both 1. A packet closes on the flit that has `srcLast`=1, or on its MAX_FLITS-th flit (4 by default), whichever comes first. `srcPort` is sampled with the first flit.
- R3: In the cycle after the closing flit is taken, the stored flits appear on `txFlit` one per cycle in arrival order, with `txValid`=1 and with `txLast`=1 on the final flit only. `txValid` and `loopValid` are never 1 together.
- R4: `srcReady` stays 0 from the cycle after a packet closes until its outcome pulse. Flits offered in that time are not taken and do not change the stored copy.
- R5: An Ack (`ackIn`=1) while the packet waits for its verdict gives, in the next cycle, `doneValid`=1 with `doneOk`=1 and `donePort` set to the packet's port. In that same cycle `srcReady` is 1 again.
- R6: A first or second consecutive Nack (`nackIn`=1) for a waiting packet restarts transmission in the next cycle, beginning again with the packet's first flit.
- R7: A third consecutive Nack sends the packet's flits, in order, on `loopFlit` with `loopValid`=1 and with `loopLast` on the final flit. Nothing goes on `txValid`. The cycle after the final loop flit has `doneValid`=1, `doneOk`=0 and `donePort` set to the packet's port.
- R8: The Nack count starts at zero for every newly loaded packet, so each packet gets two resends before it is diverted.
- R9: Ack and Nack are ignored unless a packet is waiting for its verdict: while idle or loading, during transmission and during loopback.
- R10: If Ack and Nack arrive in the same cycle while a packet waits, the Ack takes effect and the Nack is discarded.
- R11: `doneValid` is 1 for exactly one cycle per packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcValid | input | 1 | Source offers a flit |
| srcReady | output | 1 | Controller can take a flit |
| srcFlit | input | FLIT_W | Offered flit |
| srcLast | input | 1 | Offered flit closes its packet |
| srcPort | input | PORT_W | Router input port the packet entered by (sampled with the first flit) |
| txValid | output | 1 | Flit on the link is valid |
| txFlit | output | FLIT_W | Flit sent to the neighbour |
| txLast | output | 1 | Final flit of the packet on the link |
| ackIn | input | 1 | Neighbour accepted the packet |
| nackIn | input | 1 | Neighbour rejected the packet |
| loopValid | output | 1 | Flit on the loopback path is valid |
| loopFlit | output | FLIT_W | Flit diverted to the loopback path |
| loopLast | output | 1 | Final flit on the loopback path |
| doneValid | output | 1 | One-cycle outcome pulse |
| doneOk | output | 1 | 1 = delivered after Ack, 0 = diverted after three Nacks |
| donePort | output | PORT_W | Input port of the packet being reported |

## Verification
Two events can fall on the same edge: the neighbour's Ack and its Nack. The bench drives both together in the waiting cycle at the end of sweeps over every packet length and every number of earlier rejections. It expects a success pulse with no further transmission, because the Ack wins. The outcome pulse can also share a cycle with a new packet's first flit. The bench offers that flit right away and checks that the reported port is still the old packet's, and that the next stream carries the new data.

// File: rtl/linkRetryPkg.sv
package linkRetryPkg;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_LOOP = 2'd3
  } ctrlState_e;

  // strobes from control to the packet store
  typedef struct packed {
    logic loadFlit;  // write source flit at write pointer
    logic wrRst;     // rewind write pointer (packet closed)
    logic rdRst;     // rewind read pointer to first flit
    logic rdStep;    // advance read pointer
  } dpStrobe_t;

endpackage

// File: rtl/linkRetryBuf.sv
module linkRetryBuf
  import linkRetryPkg::*;
#(
  parameter int FLIT_W    = 8,
  parameter int MAX_FLITS = 4,
  parameter int PORT_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [FLIT_W-1:0] srcFlit,
  input  logic [PORT_W-1:0] srcPort,
  output logic [FLIT_W-1:0] curFlit,
  output logic              rdLast,
  output logic              wrFull,
  output logic [PORT_W-1:0] pktPort
);

  localparam int PTR_W = (MAX_FLITS > 1) ? $clog2(MAX_FLITS) : 1;

  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  lastIdx;
  logic [FLIT_W-1:0] slot [MAX_FLITS];

  // one register per flit slot, written when the pointer selects it
  for (genvar g = 0; g < MAX_FLITS; g++) begin : g_slot
    logic slotSel;
    assign slotSel = strobe.loadFlit && (wrPtr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slotSel) slot[g] <= srcFlit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      lastIdx <= '0;
      pktPort <= '0;
    end else begin
      if (strobe.loadFlit) begin
        lastIdx <= wrPtr;
        if (wrPtr == '0) pktPort <= srcPort;
      end
      if (strobe.wrRst)         wrPtr <= '0;
      else if (strobe.loadFlit) wrPtr <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdPtr <= '0;
    else if (strobe.rdRst)  rdPtr <= '0;
    else if (strobe.rdStep) rdPtr <= rdPtr + 1'b1;
  end

  assign curFlit = slot[rdPtr];
  assign rdLast  = (rdPtr == lastIdx);
  assign wrFull  = (wrPtr == PTR_W'(MAX_FLITS - 1));

endmodule

// File: rtl/linkRetryCtrl.sv
module linkRetryCtrl
  import linkRetryPkg::*;
#(
  parameter int NACK_LIMIT = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      srcValid,
  input  logic      srcLast,
  input  logic      ackIn,
  input  logic      nackIn,
  input  logic      rdLast,
  input  logic      wrFull,
  output dpStrobe_t strobe,
  output logic      srcReady,
  output logic      txValid,
  output logic      loopValid,
  output logic      doneValid,
  output logic      doneOk
);

  localparam int TRY_W = $clog2(NACK_LIMIT + 1);

  ctrlState_e       state, nextState;
  logic [TRY_W-1:0] nackCnt;
  logic             lastTry;
  logic             takeAck;
  logic             takeNack;

  assign lastTry  = (nackCnt == TRY_W'(NACK_LIMIT - 1));
  // verdicts count only while waiting; Ack has priority over Nack
  assign takeAck  = (state == ST_WAIT) && ackIn;
  assign takeNack = (state == ST_WAIT) && nackIn && !ackIn;

  always_comb begin
    strobe    = '0;
    srcReady  = 1'b0;
    txValid   = 1'b0;
    loopValid = 1'b0;
    nextState = state;
    case (state)
      ST_LOAD: begin
        srcReady = 1'b1;
        if (srcValid) begin
          strobe.loadFlit = 1'b1;
          if (srcLast || wrFull) begin
            strobe.wrRst = 1'b1;
            strobe.rdRst = 1'b1;
            nextState    = ST_SEND;
          end
        end
      end
      ST_SEND: begin
        txValid = 1'b1;
        if (rdLast) begin
          strobe.rdRst = 1'b1;
          nextState    = ST_WAIT;
        end else begin
          strobe.rdStep = 1'b1;
        end
      end
      ST_WAIT: begin
        if (takeAck) begin
          nextState = ST_LOAD;
        end else if (takeNack) begin
          strobe.rdRst = 1'b1;
          nextState    = lastTry ? ST_LOOP : ST_SEND;
        end
      end
      ST_LOOP: begin
        loopValid = 1'b1;
        if (rdLast) begin
          strobe.rdRst = 1'b1;
          nextState    = ST_LOAD;
        end else begin
          strobe.rdStep = 1'b1;
        end
      end
      default: nextState = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_LOAD;
      nackCnt   <= '0;
      doneValid <= 1'b0;
      doneOk    <= 1'b0;
    end else begin
      state     <= nextState;
      if (state == ST_LOAD) nackCnt <= '0;
      else if (takeNack)    nackCnt <= nackCnt + 1'b1;
      doneValid <= takeAck || ((state == ST_LOOP) && rdLast);
      doneOk    <= takeAck;
    end
  end

endmodule

// File: rtl/linkRetryTx.sv
module linkRetryTx
  import linkRetryPkg::*;
#(
  parameter int FLIT_W     = 8,
  parameter int MAX_FLITS  = 4,
  parameter int PORT_W     = 2,
  parameter int NACK_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcValid,
  output logic              srcReady,
  input  logic [FLIT_W-1:0] srcFlit,
  input  logic              srcLast,
  input  logic [PORT_W-1:0] srcPort,
  output logic              txValid,
  output logic [FLIT_W-1:0] txFlit,
  output logic              txLast,
  input  logic              ackIn,
  input  logic              nackIn,
  output logic              loopValid,
  output logic [FLIT_W-1:0] loopFlit,
  output logic              loopLast,
  output logic              doneValid,
  output logic              doneOk,
  output logic [PORT_W-1:0] donePort
);

  dpStrobe_t         strobe;
  logic [FLIT_W-1:0] curFlit;
  logic              rdLast;
  logic              wrFull;
  logic [PORT_W-1:0] pktPort;

  linkRetryCtrl #(.NACK_LIMIT(NACK_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcLast(srcLast),
    .ackIn(ackIn), .nackIn(nackIn), .rdLast(rdLast), .wrFull(wrFull),
    .strobe(strobe), .srcReady(srcReady), .txValid(txValid),
    .loopValid(loopValid), .doneValid(doneValid), .doneOk(doneOk)
  );

  linkRetryBuf #(.FLIT_W(FLIT_W), .MAX_FLITS(MAX_FLITS), .PORT_W(PORT_W)) u_buf (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcFlit(srcFlit),
    .srcPort(srcPort), .curFlit(curFlit), .rdLast(rdLast),
    .wrFull(wrFull), .pktPort(pktPort)
  );

  assign txFlit   = curFlit;
  assign loopFlit = curFlit;
  assign txLast   = txValid && rdLast;
  assign loopLast = loopValid && rdLast;
  assign donePort = pktPort;

endmodule

// File: rtl/linkRetryTxChk.sv
module linkRetryTxChk (
  input logic clk,
  input logic rstN,
  input logic srcReady,
  input logic txValid,
  input logic loopValid,
  input logic loopLast,
  input logic ackIn,
  input logic nackIn,
  input logic doneValid,
  input logic doneOk
);

  logic waiting;
  assign waiting = !srcReady && !txValid && !loopValid;

  p_one_path_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(txValid && loopValid));

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid || loopValid) |-> !srcReady);

  // covers R10 as well: a Nack beside the Ack does not change the result
  p_ack_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && waiting) |=> (doneValid && doneOk && srcReady));

  p_nack_resend_r6: assert property (@(posedge clk) disable iff (!rstN)
    (nackIn && !ackIn && waiting) |=> (txValid || loopValid));

  p_fail_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !doneOk) |-> $past(loopValid && loopLast));

  p_idle_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (srcReady && (ackIn || nackIn)) |=> !doneValid);

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

endmodule

bind linkRetryTx linkRetryTxChk u_chk (
  .clk(clk), .rstN(rstN), .srcReady(srcReady), .txValid(txValid),
  .loopValid(loopValid), .loopLast(loopLast), .ackIn(ackIn),
  .nackIn(nackIn), .doneValid(doneValid), .doneOk(doneOk)
);

// File: tb/test_linkRetryTx.sv
`timescale 1ns/1ps
module test_linkRetryTx;

  localparam int FLIT_W    = 8;
  localparam int MAX_FLITS = 4;
  localparam int PORT_W    = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              srcValid = 1'b0;
  logic              srcReady;
  logic [FLIT_W-1:0] srcFlit = '0;
  logic              srcLast = 1'b0;
  logic [PORT_W-1:0] srcPort = '0;
  logic              txValid;
  logic [FLIT_W-1:0] txFlit;
  logic              txLast;
  logic              ackIn = 1'b0;
  logic              nackIn = 1'b0;
  logic              loopValid;
  logic [FLIT_W-1:0] loopFlit;
  logic              loopLast;
  logic              doneValid;
  logic              doneOk;
  logic [PORT_W-1:0] donePort;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  linkRetryTx #(.FLIT_W(FLIT_W), .MAX_FLITS(MAX_FLITS), .PORT_W(PORT_W)) i_linkRetryTx (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcReady(srcReady),
    .srcFlit(srcFlit), .srcLast(srcLast), .srcPort(srcPort),
    .txValid(txValid), .txFlit(txFlit), .txLast(txLast),
    .ackIn(ackIn), .nackIn(nackIn), .loopValid(loopValid),
    .loopFlit(loopFlit), .loopLast(loopLast), .doneValid(doneValid),
    .doneOk(doneOk), .donePort(donePort)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // offer len flits; withLast marks the final one
  task automatic loadPkt(int len, int port, int base, bit withLast);
    for (int i = 0; i < len; i++) begin
      check("R2 srcReady while loading", int'(srcReady), 1);
      srcValid = 1'b1;
      srcFlit  = FLIT_W'(base + i);
      srcLast  = withLast && (i == len - 1);
      srcPort  = PORT_W'(i == 0 ? port : port ^ 1);
      step();
    end
    srcValid = 1'b0;
    srcLast  = 1'b0;
  endtask

  // expect the stored packet on the link or on the loopback path; poke a
  // stray verdict at cycle pokeAt, which must be ignored (R9)
  task automatic expectStream(bit onLoop, int len, int base, int pokeAt);
    for (int i = 0; i < len; i++) begin
      if (onLoop) begin
        check("R7 loopValid", int'(loopValid), 1);
        check("R7 no txValid on loopback", int'(txValid), 0);
        check("R7 loopFlit order", int'(loopFlit), (base + i) % 256);
        check("R7 loopLast", int'(loopLast), int'(i == len - 1));
      end else begin
        check("R3 txValid", int'(txValid), 1);
        check("R3 no loopValid", int'(loopValid), 0);
        check("R3 txFlit order", int'(txFlit), (base + i) % 256);
        check("R3 txLast", int'(txLast), int'(i == len - 1));
      end
      check("R4 srcReady low while busy", int'(srcReady), 0);
      check("R9 no outcome while streaming", int'(doneValid), 0);
      if (i == pokeAt) begin
        ackIn  = !onLoop;
        nackIn = onLoop;
      end
      step();
      ackIn  = 1'b0;
      nackIn = 1'b0;
    end
  endtask

  task automatic checkWait();
    check("R4 srcReady low while waiting", int'(srcReady), 0);
    check("R3 link idle while waiting", int'(txValid), 0);
    check("R7 loop idle while waiting", int'(loopValid), 0);
    // offer a foreign flit; it must not be taken (R4)
    srcValid = 1'b1;
    srcFlit  = 8'hEE;
    srcLast  = 1'b1;
    step();
    srcValid = 1'b0;
    srcLast  = 1'b0;
    check("R4 foreign flit not taken", int'(srcReady), 0);
  endtask

  task automatic checkDone(bit ok, int port, string tag);
    check({tag, " doneValid"}, int'(doneValid), 1);
    check({tag, " doneOk"}, int'(doneOk), int'(ok));
    check({tag, " donePort"}, int'(donePort), port);
    check("R5 ready at outcome", int'(srcReady), 1);
    step();
    check("R11 outcome lasts one cycle", int'(doneValid), 0);
  endtask

  // full packet life: nNacks rejections (3 = diversion), then Ack
  task automatic runPkt(int len, int port, int base, int nNacks, bit bothAtAck);
    loadPkt(len, port, base, 1'b1);
    expectStream(1'b0, len, base, (len > 1) ? 0 : -1);
    checkWait();
    for (int k = 0; k < nNacks && k < 3; k++) begin
      nackIn = 1'b1;
      step();
      nackIn = 1'b0;
      if (k < 2) begin
        expectStream(1'b0, len, base, -1);  // R6 full resend
        checkWait();
      end else begin
        expectStream(1'b1, len, base, (len > 1) ? 1 : -1);
        checkDone(1'b0, port, "R7 diversion");
      end
    end
    if (nNacks < 3) begin
      ackIn  = 1'b1;
      nackIn = bothAtAck;
      step();
      ackIn  = 1'b0;
      nackIn = 1'b0;
      check("R10 Ack wins, no resend", int'(txValid), 0);
      checkDone(1'b1, port, bothAtAck ? "R10 Ack with Nack" : "R5 Ack");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    check("R1 srcReady in reset", int'(srcReady), 1);
    check("R1 txValid in reset", int'(txValid), 0);
    check("R1 loopValid in reset", int'(loopValid), 0);
    check("R1 doneValid in reset", int'(doneValid), 0);
    rstN = 1'b1;
    step();
    check("R1 srcReady after reset", int'(srcReady), 1);
    check("R1 doneValid after reset", int'(doneValid), 0);

    // stray verdicts while idle (R9)
    ackIn = 1'b1;
    step();
    ackIn = 1'b0;
    check("R9 idle Ack ignored", int'(doneValid), 0);
    nackIn = 1'b1;
    step();
    nackIn = 1'b0;
    check("R9 idle Nack ignored", int'(doneValid), 0);
    check("R9 idle Nack leaves link quiet", int'(txValid), 0);

    // near-exhaustive sweep: every length, every rejection count, both
    // verdict forms; R8: each new packet restarts its Nack count
    for (int len = 1; len <= MAX_FLITS; len++)
      for (int n = 0; n <= 3; n++)
        for (int both = 0; both < 2; both++)
          runPkt(len, (len + n + both) % 4, 16 * len + 4 * n + both, n, bit'(both));

    // R8: two rejections then Ack, twice in a row, after a diversion
    runPkt(2, 1, 200, 3, 1'b0);
    runPkt(2, 2, 210, 2, 1'b0);
    runPkt(3, 3, 220, 2, 1'b0);

    // R2: no srcLast, packet closes at MAX_FLITS
    loadPkt(MAX_FLITS, 2, 100, 1'b0);
    expectStream(1'b0, MAX_FLITS, 100, -1);
    checkWait();
    ackIn = 1'b1;
    step();
    ackIn = 1'b0;
    check("R2 capped packet port", int'(donePort), 2);
    // new packet offered in the outcome cycle itself
    check("R5 outcome pulse", int'(doneValid), 1);
    srcValid = 1'b1;
    srcFlit  = 8'h55;
    srcLast  = 1'b1;
    srcPort  = 2'd1;
    step();
    srcValid = 1'b0;
    srcLast  = 1'b0;
    expectStream(1'b0, 1, 8'h55, -1);
    checkWait();
    ackIn = 1'b1;
    step();
    ackIn = 1'b0;
    checkDone(1'b1, 1, "R2 back-to-back packet");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule